// File: doc/BRIEF.md
# Virtual Partition ID Remap Table

This block translates a 5-bit virtual partition identifier into a 16-bit physical partition identifier. It is meant to sit beside a request path that carries a partition tag. Software loads the translation table through a register-style port, one 64-bit word per access. Each word packs four 16-bit physical IDs, so word `w`, entry `k` (bits `[16k+15:16k]`) holds the translation for virtual ID `4w+k`.

A parameter sets the highest word index that exists. Word 0 always exists, and at most eight words can exist. A separate 32-bit mask marks which of the 32 entries may be used.

Each lookup carries a privilege tag. The user level and the kernel level each have their own enable. A bypass input represents the case where the hypervisor level is off for the current security state, and it forces every lookup to pass through unchanged. The lookup output is combinational from registered table state.

Top module: `vpid_remap_table`

## Requirements
- R1: After reset, every implemented word reads back as zero and the valid mask reads back as zero.
- R2: A write to an implemented word index stores all 64 bits. Reads of that index return the stored value from the cycle after the write strobe.
- R3: With remapping active, a lookup of virtual ID `v` returns bits `[16(v%4)+15:16(v%4)]` of word `v/4` on `lk_pid_o`, with `lk_hit_o`=1 and `lk_err_o`=0.
- R4: A read or write to a word index above `MAX_WORD_IDX` raises `cfg_undef_o` in the same cycle. Such a write changes no table state, and such a read returns zero.
- R5: Entry `n` is usable only when bit `n` of the valid mask is 1. Looking up an active entry whose mask bit is 0 gives `lk_pid_o`=0, `lk_hit_o`=0 and `lk_err_o`=1.
- R6: The kernel enable (`en_kern_i`) gates lookups tagged kernel (`lk_priv_i`=1). The user enable (`en_user_i`) gates lookups tagged user (`lk_priv_i`=0). When the enable for the tag is 0, `lk_pid_o` is the virtual ID zero-extended, and hit and err are both 0.
- R7: While `bypass_i`=1, every lookup passes through: `lk_pid_o` is the zero-extended virtual ID, and hit and err are 0, regardless of enables or table contents.
- R8: With remapping active, a virtual ID whose word index exceeds `MAX_WORD_IDX` gives `lk_pid_o`=0, `lk_hit_o`=0 and `lk_err_o`=1.
- R9: A table write changes lookups starting the cycle after the write strobe. In the cycle of the strobe, the lookup still shows the old entry.
- R10: `lk_hit_o` and `lk_err_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Word write strobe |
| cfg_rd_i | input | 1 | Word read strobe |
| cfg_idx_i | input | 3 | Word index for read or write |
| cfg_wdata_i | input | 64 | Write data, four packed 16-bit entries |
| cfg_rdata_o | output | 64 | Read data of the selected word, zero if absent |
| cfg_undef_o | output | 1 | Access targets a word that does not exist |
| mask_we_i | input | 1 | Valid mask write strobe |
| mask_wdata_i | input | 32 | Valid mask write data |
| mask_rdata_o | output | 32 | Current valid mask |
| en_user_i | input | 1 | Remap enable for user-tagged lookups |
| en_kern_i | input | 1 | Remap enable for kernel-tagged lookups |
| bypass_i | input | 1 | Forces pass-through of all lookups |
| lk_vid_i | input | 5 | Virtual partition ID |
| lk_priv_i | input | 1 | Privilege tag: 0 user, 1 kernel |
| lk_pid_o | output | 16 | Physical (or passed-through) partition ID |
| lk_hit_o | output | 1 | Valid translation returned |
| lk_err_o | output | 1 | Invalid or out-of-range entry |

## Verification
The hardest case to reach from the ports is a write to a word that does not exist, because no port shows directly that nothing changed. With the default parameter every index exists. The bench therefore builds the table with `MAX_WORD_IDX`=5, which makes indices 6 and 7 illegal. It then writes to them and reads back every legal word and the out-of-range lookups afterwards. The same-cycle visibility rule is covered by a lookup of an entry whose word is being rewritten in that cycle, sampled before and after the clock edge.

// File: rtl/vpid_remap_pkg.sv
package vpid_remap_pkg;
  localparam int unsigned PID_W        = 16;
  localparam int unsigned ENT_PER_WORD = 4;
  localparam int unsigned WORD_W       = PID_W * ENT_PER_WORD;
  localparam int unsigned MAX_WORDS    = 8;
  localparam int unsigned IDX_W        = $clog2(MAX_WORDS);
  localparam int unsigned ENT_IDX_W    = $clog2(ENT_PER_WORD);
  localparam int unsigned MASK_W       = MAX_WORDS * ENT_PER_WORD;
  localparam int unsigned VID_W        = $clog2(MASK_W);

  typedef enum logic {
    PRIV_USER = 1'b0,
    PRIV_KERN = 1'b1
  } priv_e;

  typedef logic [ENT_PER_WORD-1:0][PID_W-1:0] word_t;
endpackage

// File: rtl/vpid_cfg_regs.sv
module vpid_cfg_regs
  import vpid_remap_pkg::*;
#(
  parameter int unsigned NUM_WORDS = MAX_WORDS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  word_t                  wdata_i,
  input  logic                   mask_we_i,
  input  logic [MASK_W-1:0]      mask_wdata_i,
  output word_t [NUM_WORDS-1:0]  words_o,
  output logic  [MASK_W-1:0]     mask_o
);
  word_t [NUM_WORDS-1:0] words_q;
  logic  [MASK_W-1:0]    mask_q;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                words_q[g] <= '0;
      else if (wr_en_i && idx_i == IDX_W'(g))     words_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  assign words_o = words_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/vpid_cfg_decode.sv
module vpid_cfg_decode
  import vpid_remap_pkg::*;
#(
  parameter int unsigned NUM_WORDS = MAX_WORDS
) (
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  word_t [NUM_WORDS-1:0] words_i,
  output logic                  wr_ok_o,
  output logic                  undef_o,
  output logic [WORD_W-1:0]     rdata_o
);
  logic exists;
  word_t sel;

  always_comb begin
    exists = 1'b0;
    sel    = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (idx_i == IDX_W'(w)) begin
        exists = 1'b1;
        sel    = words_i[w];
      end
    end
  end

  assign wr_ok_o = wr_i & exists;
  assign undef_o = (wr_i | rd_i) & ~exists;
  assign rdata_o = sel;
endmodule

// File: rtl/vpid_lookup.sv
module vpid_lookup
  import vpid_remap_pkg::*;
#(
  parameter int unsigned NUM_WORDS = MAX_WORDS
) (
  input  word_t [NUM_WORDS-1:0] words_i,
  input  logic [MASK_W-1:0]     mask_i,
  input  logic [VID_W-1:0]      vid_i,
  input  logic                  priv_i,
  input  logic                  en_user_i,
  input  logic                  en_kern_i,
  input  logic                  bypass_i,
  output logic [PID_W-1:0]      pid_o,
  output logic                  hit_o,
  output logic                  err_o
);
  logic [IDX_W-1:0]     word_idx;
  logic [ENT_IDX_W-1:0] ent_idx;
  logic                 in_range;
  logic                 remap_on;
  logic [PID_W-1:0]     entry;

  assign word_idx = vid_i[VID_W-1:ENT_IDX_W];
  assign ent_idx  = vid_i[ENT_IDX_W-1:0];
  assign remap_on = ~bypass_i & ((priv_i == PRIV_KERN) ? en_kern_i : en_user_i);

  always_comb begin
    in_range = 1'b0;
    entry    = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_idx == IDX_W'(w)) begin
        in_range = 1'b1;
        entry    = words_i[w][ent_idx];
      end
    end
  end

  always_comb begin
    pid_o = PID_W'(vid_i);
    hit_o = 1'b0;
    err_o = 1'b0;
    if (remap_on) begin
      if (in_range && mask_i[vid_i]) begin
        pid_o = entry;
        hit_o = 1'b1;
      end else begin
        pid_o = '0;
        err_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpid_remap_table.sv
module vpid_remap_table
  import vpid_remap_pkg::*;
#(
  parameter int unsigned MAX_WORD_IDX = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic              cfg_rd_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  output logic [WORD_W-1:0] cfg_rdata_o,
  output logic              cfg_undef_o,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  output logic [MASK_W-1:0] mask_rdata_o,
  input  logic              en_user_i,
  input  logic              en_kern_i,
  input  logic              bypass_i,
  input  logic [VID_W-1:0]  lk_vid_i,
  input  logic              lk_priv_i,
  output logic [PID_W-1:0]  lk_pid_o,
  output logic              lk_hit_o,
  output logic              lk_err_o
);
  localparam int unsigned NUM_WORDS = MAX_WORD_IDX + 1;

  word_t [NUM_WORDS-1:0] tbl_words;
  logic  [MASK_W-1:0]    tbl_mask;
  logic                  wr_ok;

  vpid_cfg_decode #(.NUM_WORDS(NUM_WORDS)) u_decode (
    .wr_i    (cfg_wr_i),
    .rd_i    (cfg_rd_i),
    .idx_i   (cfg_idx_i),
    .words_i (tbl_words),
    .wr_ok_o (wr_ok),
    .undef_o (cfg_undef_o),
    .rdata_o (cfg_rdata_o)
  );

  vpid_cfg_regs #(.NUM_WORDS(NUM_WORDS)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_ok),
    .idx_i        (cfg_idx_i),
    .wdata_i      (cfg_wdata_i),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .words_o      (tbl_words),
    .mask_o       (tbl_mask)
  );

  vpid_lookup #(.NUM_WORDS(NUM_WORDS)) u_lookup (
    .words_i   (tbl_words),
    .mask_i    (tbl_mask),
    .vid_i     (lk_vid_i),
    .priv_i    (lk_priv_i),
    .en_user_i (en_user_i),
    .en_kern_i (en_kern_i),
    .bypass_i  (bypass_i),
    .pid_o     (lk_pid_o),
    .hit_o     (lk_hit_o),
    .err_o     (lk_err_o)
  );

  assign mask_rdata_o = tbl_mask;
endmodule

// File: rtl/vpid_remap_checker.sv
module vpid_remap_checker
  import vpid_remap_pkg::*;
#(
  parameter int unsigned MAX_WORD_IDX = 7
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             cfg_wr_i,
  input logic                             cfg_rd_i,
  input logic [WORD_W-1:0]                cfg_rdata_o,
  input logic                             cfg_undef_o,
  input logic [MASK_W-1:0]                mask_rdata_o,
  input logic                             en_user_i,
  input logic                             en_kern_i,
  input logic                             bypass_i,
  input logic [VID_W-1:0]                 lk_vid_i,
  input logic                             lk_priv_i,
  input logic [PID_W-1:0]                 lk_pid_o,
  input logic                             lk_hit_o,
  input logic                             lk_err_o,
  input logic [(MAX_WORD_IDX+1)*WORD_W-1:0] words_i
);
  p_hit_err_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_err_o));

  p_undef_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rd_i && cfg_undef_o) |-> cfg_rdata_o == '0);

  p_undef_write_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_undef_o) |=> $stable(words_i));

  p_bypass_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> (lk_pid_o == PID_W'(lk_vid_i) && !lk_hit_o && !lk_err_o));

  p_hit_needs_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> mask_rdata_o[lk_vid_i]);

  p_priv_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lk_priv_i ? !en_kern_i : !en_user_i)) |->
      (lk_pid_o == PID_W'(lk_vid_i) && !lk_hit_o && !lk_err_o));
endmodule

bind vpid_remap_table vpid_remap_checker #(.MAX_WORD_IDX(MAX_WORD_IDX)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_wr_i     (cfg_wr_i),
  .cfg_rd_i     (cfg_rd_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .cfg_undef_o  (cfg_undef_o),
  .mask_rdata_o (mask_rdata_o),
  .en_user_i    (en_user_i),
  .en_kern_i    (en_kern_i),
  .bypass_i     (bypass_i),
  .lk_vid_i     (lk_vid_i),
  .lk_priv_i    (lk_priv_i),
  .lk_pid_o     (lk_pid_o),
  .lk_hit_o     (lk_hit_o),
  .lk_err_o     (lk_err_o),
  .words_i      (tbl_words)
);

// File: tb/vpid_remap_table_bench.sv
module vpid_remap_table_bench;
  localparam int unsigned MAXW  = 5;
  localparam int unsigned NV    = 12;
  localparam logic [31:0] MASKV = 32'hFF7F_FFF7;

  // {vid[5], priv, en_user, en_kern, bypass, pid[16], hit, err}
  localparam logic [26:0] VECS [NV] = '{
    {5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 16'h8003, 1'b1, 1'b0},  // R3
    {5'd5,  1'b0, 1'b1, 1'b0, 1'b0, 16'h8053, 1'b1, 1'b0},  // R3 R6
    {5'd5,  1'b0, 1'b0, 1'b1, 1'b0, 16'h0005, 1'b0, 1'b0},  // R6
    {5'd5,  1'b1, 1'b1, 1'b0, 1'b0, 16'h0005, 1'b0, 1'b0},  // R6
    {5'd22, 1'b1, 1'b1, 1'b1, 1'b0, 16'h8163, 1'b1, 1'b0},  // R3
    {5'd3,  1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},  // R5
    {5'd23, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},  // R5
    {5'd24, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},  // R8
    {5'd31, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1},  // R8
    {5'd22, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0016, 1'b0, 1'b0},  // R7
    {5'd24, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0018, 1'b0, 1'b0},  // R7
    {5'd21, 1'b0, 1'b1, 1'b1, 1'b0, 16'h8153, 1'b1, 1'b0}   // R3
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        cfg_undef;
  logic        mask_we = 1'b0;
  logic [31:0] mask_wdata = '0;
  logic [31:0] mask_rdata;
  logic        en_user = 1'b0, en_kern = 1'b0, bypass = 1'b0;
  logic [4:0]  vid = '0;
  logic        priv = 1'b0;
  logic [15:0] pid;
  logic        hit, err;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  vpid_remap_table #(.MAX_WORD_IDX(MAXW)) u_vpid_remap_table (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_wr_i(cfg_wr), .cfg_rd_i(cfg_rd), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .cfg_undef_o(cfg_undef),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .mask_rdata_o(mask_rdata),
    .en_user_i(en_user), .en_kern_i(en_kern), .bypass_i(bypass),
    .lk_vid_i(vid), .lk_priv_i(priv),
    .lk_pid_o(pid), .lk_hit_o(hit), .lk_err_o(err)
  );

  function automatic logic [15:0] ent_pid(int n);
    return 16'h8003 | (16'(n) << 4);
  endfunction

  function automatic logic [63:0] word_val(int w);
    return {ent_pid(4*w+3), ent_pid(4*w+2), ent_pid(4*w+1), ent_pid(4*w)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(logic [2:0] idx, logic [63:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_word(logic [2:0] idx);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_idx = idx;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    for (int w = 0; w <= int'(MAXW); w++) begin
      rd_word(3'(w));
      chk("R1 word", cfg_rdata, 64'h0);
    end
    cfg_rd = 1'b0;
    chk("R1 mask", {32'h0, mask_rdata}, 64'h0);
    @(negedge clk);
    en_kern = 1'b1; priv = 1'b1; vid = 5'd0; #1;
    chk("R1 lookup err", {63'h0, err}, 64'h1);

    // R2: load and read back
    for (int w = 0; w <= int'(MAXW); w++) wr_word(3'(w), word_val(w));
    for (int w = 0; w <= int'(MAXW); w++) begin
      rd_word(3'(w));
      chk("R2 readback", cfg_rdata, word_val(w));
      chk("R2 no undef", {63'h0, cfg_undef}, 64'h0);
    end
    cfg_rd = 1'b0;
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = MASKV;
    @(negedge clk);
    mask_we = 1'b0;
    chk("R5 mask readback", {32'h0, mask_rdata}, {32'h0, MASKV});

    // table walk: R3 R5 R6 R7 R8 R10
    for (int i = 0; i < int'(NV); i++) begin
      @(negedge clk);
      vid = VECS[i][26:22]; priv = VECS[i][21];
      en_user = VECS[i][20]; en_kern = VECS[i][19]; bypass = VECS[i][18];
      #1;
      chk("R3/R5/R6/R7/R8 pid", {48'h0, pid}, {48'h0, VECS[i][17:2]});
      chk("R3/R5/R6/R7/R8 hit", {63'h0, hit}, {63'h0, VECS[i][1]});
      chk("R3/R5/R6/R7/R8 err", {63'h0, err}, {63'h0, VECS[i][0]});
      chk("R10 exclusive", {63'h0, hit & err}, 64'h0);
    end

    // R9: write visible only after the strobe edge
    @(negedge clk);
    bypass = 1'b0; en_kern = 1'b1; priv = 1'b1; vid = 5'd5;
    cfg_wr = 1'b1; cfg_idx = 3'd1;
    cfg_wdata = {word_val(1)[63:32], 16'hBEEF, word_val(1)[15:0]};
    #1;
    chk("R9 old before edge", {48'h0, pid}, {48'h0, ent_pid(5)});
    @(negedge clk);
    cfg_wr = 1'b0; #1;
    chk("R9 new after edge", {48'h0, pid}, 64'hBEEF);
    wr_word(3'd1, word_val(1));

    // R4: absent words 6 and 7
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 3'd6; cfg_wdata = 64'hDEAD_BEEF_CAFE_F00D; #1;
    chk("R4 undef on write", {63'h0, cfg_undef}, 64'h1);
    @(negedge clk);
    cfg_idx = 3'd7;
    @(negedge clk);
    cfg_wr = 1'b0;
    rd_word(3'd6);
    chk("R4 undef on read", {63'h0, cfg_undef}, 64'h1);
    chk("R4 read zero", cfg_rdata, 64'h0);
    rd_word(3'd7);
    chk("R4 read zero w7", cfg_rdata, 64'h0);
    for (int w = 0; w <= int'(MAXW); w++) begin
      rd_word(3'(w));
      chk("R4 legal words kept", cfg_rdata, word_val(w));
    end
    cfg_rd = 1'b0;
    @(negedge clk);
    vid = 5'd26; priv = 1'b1; #1;
    chk("R4/R8 absent word lookup err", {63'h0, err}, 64'h1);
    chk("R4/R8 absent word lookup pid", {48'h0, pid}, 64'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule